// File: doc/BRIEF.md
# Byte ALU with Destination Select

This block is the arithmetic and logic stage of a small accumulator-style processor core. Each cycle it receives a file-register operand, the working register value, an immediate byte, the present carry flag, a 3-bit operation code and a destination bit. It returns one result byte and two write strobes. One strobe targets the working register and the other targets the file register. It also returns carry, digit-carry and zero flag values, each with its own update strobe. The surrounding core applies only the flags whose strobe is high.

The unit is purely combinational and has no state. The instruction decoder places the operation code and the destination bit on the inputs. The register file supplies the operand. The result is written back at the next clock edge as the strobes select.

Operation codes: 000 rotate left through carry, 001 rotate right through carry, 010 subtract W from f, 011 swap nibbles, 100 load immediate into W. Codes 101 to 111 are idle codes.

Top module: `byte_alu`

## Requirements
- R1: Op 000 gives result = {f[6:0], c_in} and c_out = f[7].
- R2: Op 001 gives result = {c_in, f[7:1]} and c_out = f[0].
- R3: For ops 000 and 001, c_we is 1 while dc_we and z_we are both 0.
- R4: Op 010 gives result = (f - W) mod 256, and c_we, dc_we and z_we are all 1.
- R5: For op 010, c_out = 1 exactly when f >= W (unsigned), dc_out = 1 exactly when f[3:0] >= W[3:0], and z_out = 1 exactly when the result is zero.
- R6: Op 011 gives result = {f[3:0], f[7:4]} with all three flag strobes 0.
- R7: For ops 000 to 011, dest_f = 0 raises wr_w alone and dest_f = 1 raises wr_f alone.
- R8: Op 100 gives result = lit, wr_w = 1 and wr_f = 0 whatever dest_f is, and all flag strobes 0.
- R9: Ops 101, 110 and 111 give result 0, no write strobe and no flag strobe.
- R10: When a flag strobe is 0, its flag output is a fixed value. c_out then equals c_in, and dc_out and z_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| f_in | input | DATA_W | File-register operand |
| w_in | input | DATA_W | Working register value |
| lit_in | input | DATA_W | Immediate byte for the load operation |
| c_in | input | 1 | Present carry flag |
| op | input | 3 | Operation code |
| dest_f | input | 1 | Destination: 0 = W, 1 = file register |
| result | output | DATA_W | Operation result |
| wr_w | output | 1 | Write strobe for W |
| wr_f | output | 1 | Write strobe for the file register |
| c_out | output | 1 | New carry value |
| dc_out | output | 1 | New digit-carry value |
| z_out | output | 1 | New zero value |
| c_we | output | 1 | Carry update strobe |
| dc_we | output | 1 | Digit-carry update strobe |
| z_we | output | 1 | Zero update strobe |

## Verification
The bench builds the unit with the default DATA_W of 8. At that width every nibble boundary and every borrow case can be reached directly. The directed vectors cover these cases: equal operands, which give a zero result, and f = W + 1, which gives no borrow. They also cover a borrow out of the low nibble only, a borrow out of the whole byte, and rotates of 0x80 and 0x01 with both carry values. A few hundred random vectors then run across all eight operation codes and both destination values.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        OP_ROL  = 3'b000,
        OP_ROR  = 3'b001,
        OP_SUB  = 3'b010,
        OP_SWAP = 3'b011,
        OP_LIT  = 3'b100
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } flag_t;

    function automatic logic op_uses_dest(input logic [2:0] code);
        return code inside {OP_ROL, OP_ROR, OP_SUB, OP_SWAP};
    endfunction

endpackage

// File: rtl/byte_alu_rotate.sv
module byte_alu_rotate #(
    parameter int W    = 8,
    parameter bit LEFT = 1'b1
) (
    input  logic [W-1:0] src,
    input  logic         cin,
    output logic [W-1:0] dst,
    output logic         cout
);
    generate
        if (LEFT) begin : g_left
            assign dst  = {src[W-2:0], cin};
            assign cout = src[W-1];
        end else begin : g_right
            assign dst  = {cin, src[W-1:1]};
            assign cout = src[0];
        end
    endgenerate
endmodule

// File: rtl/byte_alu_sub.sv
module byte_alu_sub #(
    parameter int W = 8
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    output logic [W-1:0]      diff,
    output byte_alu_pkg::flag_t flg
);
    localparam int H = W / 2;

    logic [W:0] full_sum;
    logic [H:0] low_sum;

    // two's-complement addition: a + ~b + 1; carry-out means no borrow
    assign full_sum = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
    assign low_sum  = {1'b0, a[H-1:0]} + {1'b0, ~b[H-1:0]} + (H+1)'(1);

    assign diff   = full_sum[W-1:0];
    assign flg.c  = full_sum[W];
    assign flg.dc = low_sum[H];
    assign flg.z  = (full_sum[W-1:0] == '0);
endmodule

// File: rtl/byte_alu_swap.sv
module byte_alu_swap #(
    parameter int W = 8
) (
    input  logic [W-1:0] src,
    output logic [W-1:0] dst
);
    localparam int H = W / 2;
    assign dst = {src[H-1:0], src[W-1:H]};
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int DATA_W = byte_alu_pkg::DATA_W
) (
    input  logic [DATA_W-1:0] f_in,
    input  logic [DATA_W-1:0] w_in,
    input  logic [DATA_W-1:0] lit_in,
    input  logic              c_in,
    input  logic [2:0]        op,
    input  logic              dest_f,
    output logic [DATA_W-1:0] result,
    output logic              wr_w,
    output logic              wr_f,
    output logic              c_out,
    output logic              dc_out,
    output logic              z_out,
    output logic              c_we,
    output logic              dc_we,
    output logic              z_we
);
    logic [DATA_W-1:0] rol_res, ror_res, sub_res, swp_res;
    logic              rol_c, ror_c;
    flag_t             sub_flg;
    flag_t             new_flg;
    flag_t             flg_en;
    alu_op_e           op_e;

    assign op_e = alu_op_e'(op);

    byte_alu_rotate #(.W(DATA_W), .LEFT(1'b1)) u_rol (
        .src(f_in), .cin(c_in), .dst(rol_res), .cout(rol_c)
    );
    byte_alu_rotate #(.W(DATA_W), .LEFT(1'b0)) u_ror (
        .src(f_in), .cin(c_in), .dst(ror_res), .cout(ror_c)
    );
    byte_alu_sub #(.W(DATA_W)) u_sub (
        .a(f_in), .b(w_in), .diff(sub_res), .flg(sub_flg)
    );
    byte_alu_swap #(.W(DATA_W)) u_swp (
        .src(f_in), .dst(swp_res)
    );

    always_comb begin
        result  = '0;
        new_flg = '{c: c_in, dc: 1'b0, z: 1'b0};
        flg_en  = '0;
        unique case (op_e)
            OP_ROL: begin
                result    = rol_res;
                new_flg.c = rol_c;
                flg_en.c  = 1'b1;
            end
            OP_ROR: begin
                result    = ror_res;
                new_flg.c = ror_c;
                flg_en.c  = 1'b1;
            end
            OP_SUB: begin
                result  = sub_res;
                new_flg = sub_flg;
                flg_en  = '{c: 1'b1, dc: 1'b1, z: 1'b1};
            end
            OP_SWAP: result = swp_res;
            OP_LIT:  result = lit_in;
            default: result = '0;
        endcase
    end

    assign wr_w   = (op_e == OP_LIT) || (op_uses_dest(op) && !dest_f);
    assign wr_f   = op_uses_dest(op) && dest_f;
    assign c_out  = new_flg.c;
    assign dc_out = new_flg.dc;
    assign z_out  = new_flg.z;
    assign c_we   = flg_en.c;
    assign dc_we  = flg_en.dc;
    assign z_we   = flg_en.z;
endmodule

// File: rtl/byte_alu_checker.sv
module byte_alu_checker #(
    parameter int W = 8
) (
    input logic [W-1:0] f_in,
    input logic [W-1:0] w_in,
    input logic [W-1:0] lit_in,
    input logic         c_in,
    input logic [2:0]   op,
    input logic         dest_f,
    input logic [W-1:0] result,
    input logic         wr_w,
    input logic         wr_f,
    input logic         c_out,
    input logic         dc_out,
    input logic         z_out,
    input logic         c_we,
    input logic         dc_we,
    input logic         z_we
);
    always_comb begin
        assert_one_target_R7: assert (!(wr_w && wr_f))
            else $error("both write strobes high");
        if (op == 3'b000 || op == 3'b001) begin
            assert_rot_carry_only_R3: assert (c_we && !dc_we && !z_we)
                else $error("rotate flag strobes wrong");
        end
        if (op == 3'b010) begin
            assert_sub_carry_R5: assert (c_out == (f_in >= w_in))
                else $error("subtract carry wrong");
            assert_sub_zero_R5: assert (z_out == (f_in == w_in))
                else $error("subtract zero wrong");
        end
        if (op == 3'b011) begin
            assert_swap_no_flags_R6: assert (!c_we && !dc_we && !z_we)
                else $error("swap raised a flag strobe");
        end
        if (op == 3'b100) begin
            assert_lit_to_w_R8: assert (wr_w && !wr_f && result == lit_in)
                else $error("literal load wrong");
        end
        if (op[2] && op[1:0] != 2'b00) begin
            assert_idle_quiet_R9: assert (!wr_w && !wr_f && !c_we && !dc_we && !z_we)
                else $error("idle code produced activity");
        end
        if (!c_we) begin
            assert_carry_hold_R10: assert (c_out == c_in)
                else $error("carry not held");
        end
        if (!dest_f && (op == 3'b000 || op == 3'b001 || op == 3'b010 || op == 3'b011)) begin
            assert_dest_w_R7: assert (wr_w && !wr_f)
                else $error("dest W not honoured");
        end
    end
endmodule

bind byte_alu byte_alu_checker #(.W(DATA_W)) u_chk (
    .f_in(f_in), .w_in(w_in), .lit_in(lit_in), .c_in(c_in), .op(op),
    .dest_f(dest_f), .result(result), .wr_w(wr_w), .wr_f(wr_f),
    .c_out(c_out), .dc_out(dc_out), .z_out(z_out),
    .c_we(c_we), .dc_we(dc_we), .z_we(z_we)
);

// File: tb/byte_alu_test.sv
module byte_alu_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] f_in = '0, w_in = '0, lit_in = '0;
    logic       c_in = 1'b0, dest_f = 1'b0;
    logic [2:0] op = 3'b111;
    logic [7:0] result;
    logic       wr_w, wr_f, c_out, dc_out, z_out, c_we, dc_we, z_we;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    byte_alu uut (
        .f_in(f_in), .w_in(w_in), .lit_in(lit_in), .c_in(c_in), .op(op),
        .dest_f(dest_f), .result(result), .wr_w(wr_w), .wr_f(wr_f),
        .c_out(c_out), .dc_out(dc_out), .z_out(z_out),
        .c_we(c_we), .dc_we(dc_we), .z_we(z_we)
    );

    task automatic cmp(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference, evaluated on integers
    task automatic check_now();
        int f, w, l, c, res, ec, edc, ez, ewc, ewdc, ewz, eww, ewf;
        string rq;
        f = f_in; w = w_in; l = lit_in; c = c_in;
        ec = c; edc = 0; ez = 0; ewc = 0; ewdc = 0; ewz = 0;
        eww = 0; ewf = 0; res = 0; rq = "R9";
        case (op)
            3'd0: begin res = ((f * 2) + c) % 256; ec = f / 128; ewc = 1; rq = "R1"; end
            3'd1: begin res = (c * 128) + (f / 2); ec = f % 2; ewc = 1; rq = "R2"; end
            3'd2: begin
                res = (f - w + 256) % 256;
                ec = (f >= w); edc = ((f % 16) >= (w % 16)); ez = (res == 0);
                ewc = 1; ewdc = 1; ewz = 1; rq = "R4";
            end
            3'd3: begin res = ((f % 16) * 16) + (f / 16); rq = "R6"; end
            3'd4: begin res = l; rq = "R8"; end
            default: ;
        endcase
        if (op <= 3'd3) begin eww = !dest_f; ewf = dest_f; end
        if (op == 3'd4) eww = 1;
        cmp(rq, "result", result, res);
        cmp((op == 3'd4) ? "R8" : (op > 3'd4) ? "R9" : "R7", "wr_w", wr_w, eww);
        cmp((op == 3'd4) ? "R8" : (op > 3'd4) ? "R9" : "R7", "wr_f", wr_f, ewf);
        cmp((op == 3'd2) ? "R5" : (op <= 3'd1) ? "R1/R2" : "R10", "c_out", c_out, ec);
        cmp((op == 3'd2) ? "R5" : "R10", "dc_out", dc_out, edc);
        cmp((op == 3'd2) ? "R5" : "R10", "z_out", z_out, ez);
        cmp((op <= 3'd1) ? "R3" : (op == 3'd2) ? "R4" : "R6", "c_we", c_we, ewc);
        cmp((op <= 3'd1) ? "R3" : (op == 3'd2) ? "R4" : "R6", "dc_we", dc_we, ewdc);
        cmp((op <= 3'd1) ? "R3" : (op == 3'd2) ? "R4" : "R6", "z_we", z_we, ewz);
    endtask

    task automatic apply(input logic [2:0] o, input logic [7:0] f, input logic [7:0] w,
                         input logic [7:0] l, input logic c, input logic d);
        @(negedge clk);
        op = o; f_in = f; w_in = w; lit_in = l; c_in = c; dest_f = d;
        #5;
        check_now();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: idle code, nothing written (R9)
        @(negedge clk); #5;
        cmp("R9", "reset wr_w", wr_w, 0);
        cmp("R9", "reset c_we", c_we, 0);
        // R1 / R2 rotate corners
        apply(3'd0, 8'h80, 8'h00, 8'h00, 1'b0, 1'b0);
        apply(3'd0, 8'h80, 8'h00, 8'h00, 1'b1, 1'b1);
        apply(3'd0, 8'h7F, 8'h00, 8'h00, 1'b1, 1'b0);
        apply(3'd1, 8'h01, 8'h00, 8'h00, 1'b0, 1'b1);
        apply(3'd1, 8'h01, 8'h00, 8'h00, 1'b1, 1'b0);
        apply(3'd1, 8'hFE, 8'h00, 8'h00, 1'b1, 1'b1);
        // R4 / R5 subtract corners
        apply(3'd2, 8'h5A, 8'h5A, 8'h00, 1'b0, 1'b0);
        apply(3'd2, 8'h43, 8'h42, 8'h00, 1'b0, 1'b1);
        apply(3'd2, 8'h50, 8'h21, 8'h00, 1'b1, 1'b0);
        apply(3'd2, 8'h10, 8'h20, 8'h00, 1'b1, 1'b1);
        apply(3'd2, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0);
        apply(3'd2, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b1);
        // R6 swap, R8 literal with both dest values, R9 idle codes
        apply(3'd3, 8'hA5, 8'h00, 8'h00, 1'b1, 1'b0);
        apply(3'd3, 8'h0F, 8'h00, 8'h00, 1'b0, 1'b1);
        apply(3'd4, 8'h12, 8'h34, 8'hC3, 1'b1, 1'b0);
        apply(3'd4, 8'h12, 8'h34, 8'h3C, 1'b0, 1'b1);
        apply(3'd5, 8'hFF, 8'h01, 8'h77, 1'b1, 1'b1);
        apply(3'd6, 8'hFF, 8'h01, 8'h77, 1'b0, 1'b0);
        apply(3'd7, 8'hFF, 8'h01, 8'h77, 1'b1, 1'b0);
        // random sweep across all codes (R7, R10 and the rest)
        for (int i = 0; i < 400; i++) begin
            apply(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom),
                  8'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule